// File: doc/BRIEF.md
# Data Cache Maintenance Controller

A small direct-mapped write-back data cache that serves 64-bit loads and stores and also runs line-maintenance requests. Each request carries a base operand, the register index that base came from, and an index operand. The effective address is their sum, except that a base register index of 0 makes the base a literal zero. Maintenance requests act on the whole 128-byte line that holds the effective address. They can flush it (write back if dirty, then drop it), clean it (write back and keep it), discard it (drop it without write back, privileged only), or allocate it filled with zeros without reading memory.

The CPU side takes one request at a time and returns a single-cycle response with an error flag and, for loads, the data. The memory side moves whole lines. It sends a command (line address plus direction), then sixteen 64-bit beats in increasing address order. Write beats use a ready/valid handshake. Read beats arrive with a valid strobe. An access-fault input that comes with the request aborts it.

Top module: `dcm_ctrl`

## Requirements
- R1: The effective address (EA) is req_base + req_index; when req_base_sel is 0 the base is taken as zero regardless of req_base.
- R2: The line is selected by EA[9:7] (index) and EA[31:10] (tag); EA[6:0] do not affect which line a maintenance request hits, and a load or store accesses the 64-bit word EA[6:3] of the line.
- R3: Flush on a dirty hit issues one write command at the line-aligned address and sixteen beats in increasing address order, then invalidates the line; a clean hit is invalidated with no traffic; a later load of the line refills it from memory.
- R4: Clean on a dirty hit writes the line back and leaves it valid and clean, so a repeated clean makes no traffic and a later load hits.
- R5: Discard with req_priv=1 invalidates a hit line with no write back, losing dirty data; with req_priv=0 it returns an error and leaves the line unchanged.
- R6: Allocate-and-zero makes the line read as zero without any memory read command; a dirty victim in the slot is written back first; the zeroed line is dirty and is written back when evicted.
- R7: A request with req_fault=1 returns an error, moves no memory traffic and changes no cache state.
- R8: Flush, clean and discard that miss complete without error and without memory traffic.
- R9: Operation codes are 0 load, 1 store, 2 flush, 3 clean, 4 discard, 5 allocate-and-zero; codes 6 and 7 return an error; every response that is not a load returns rsp_rdata = 0.
- R10: req_ready falls in the cycle after a request is accepted and stays low until the cycle after the response; rsp_valid lasts one cycle; a pending memory command or write beat holds its values until accepted.
- R11: A load or store miss writes back a dirty victim, then refills the line with sixteen read beats before completing; a store marks its line dirty.
- R12: After reset every line is invalid, req_ready is high and no memory command or write beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 3 | Operation code (R9) |
| req_base_sel | input | 5 | Register index of the base operand; 0 means literal zero |
| req_base | input | 32 | Base operand value |
| req_index | input | 32 | Index operand value |
| req_wdata | input | 64 | Store data |
| req_priv | input | 1 | Request issued in privileged mode |
| req_fault | input | 1 | Access fault for the target address |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request was rejected or aborted |
| rsp_rdata | output | 64 | Load data, zero otherwise |
| mem_cmd_valid | output | 1 | Line command present |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = line write, 0 = line read |
| mem_cmd_addr | output | 32 | Line-aligned byte address |
| mem_wvalid | output | 1 | Write beat present |
| mem_wready | input | 1 | Memory accepts the write beat |
| mem_wdata | output | 64 | Write beat data |
| mem_rvalid | input | 1 | Read beat present |
| mem_rdata | input | 64 | Read beat data |

## Verification
In the lookup cycle, the fault and privilege screening and the hit/dirty decision that would start a write back are resolved together, and the rejection must win. A flush with the fault input raised against a freshly stored dirty line provokes this. It is judged by an error response with no write beats, and by a following load that still hits and returns the stored word. The same cycle also serves allocate-and-zero against a dirty victim, where eviction and installation share one request. That case is judged by the victim's data reappearing on a later refill, and by no read command being issued.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_FLUSH   = 3'd2,
    OP_CLEAN   = 3'd3,
    OP_DISCARD = 3'd4,
    OP_ZERO    = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    TS_NONE,
    TS_FILL_CLEAN,
    TS_FILL_DIRTY,
    TS_MARK_DIRTY,
    TS_MARK_CLEAN,
    TS_DROP
  } ts_cmd_e;

endpackage

// File: rtl/dcm_ea_gen.sv
module dcm_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] base_sel,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] base_eff;

  // register index zero selects a literal zero base (R1)
  assign base_eff = (base_sel == '0) ? '0 : base_val;
  assign ea       = base_eff + index_val;
endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store
  import dcm_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int TAG_W  = 22,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  ts_cmd_e          cmd,
  input  logic [TAG_W-1:0] new_tag,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [NLINES-1:0] vld;
  logic [NLINES-1:0] drt;
  logic [TAG_W-1:0]  tags [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic sel;
    assign sel = (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
        drt[g] <= 1'b0;
      end else if (sel) begin
        case (cmd)
          TS_FILL_CLEAN: begin vld[g] <= 1'b1; drt[g] <= 1'b0; end
          TS_FILL_DIRTY: begin vld[g] <= 1'b1; drt[g] <= 1'b1; end
          TS_MARK_DIRTY: drt[g] <= 1'b1;
          TS_MARK_CLEAN: drt[g] <= 1'b0;
          TS_DROP:       begin vld[g] <= 1'b0; drt[g] <= 1'b0; end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (sel && (cmd == TS_FILL_CLEAN || cmd == TS_FILL_DIRTY))
        tags[g] <= new_tag;
    end
  end

  assign valid_o = vld[idx];
  assign dirty_o = drt[idx];
  assign tag_o   = tags[idx];
endmodule

// File: rtl/dcm_line_ram.sv
module dcm_line_ram #(
  parameter int W     = 64,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NLINES     = 8,
  parameter int LINE_BYTES = 128,
  parameter int BEAT_W     = 64,
  parameter int RIDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [RIDX_W-1:0] req_base_sel,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [BEAT_W-1:0] req_wdata,
  input  logic              req_priv,
  input  logic              req_fault,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BEAT_W-1:0] rsp_rdata,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [BEAT_W-1:0] mem_rdata
);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(NLINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int BEATS   = LINE_BYTES * 8 / BEAT_W;
  localparam int BEAT_IW = $clog2(BEATS);
  localparam int WLSB    = $clog2(BEAT_W / 8);
  localparam int RAM_AW  = IDX_W + BEAT_IW;
  localparam logic [BEAT_IW-1:0] LAST_BEAT = BEAT_IW'(BEATS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_WB_CMD, S_WB_RD, S_WB_BEAT,
    S_RF_CMD, S_RF_DATA, S_ZFILL, S_RD
  } st_e;

  st_e               st, nxt;
  logic [ADDR_W-1:0] ea_c, ea_q;
  logic [2:0]        op_q;
  logic              priv_q, fault_q;
  logic [BEAT_W-1:0] wd_q;
  logic [BEAT_IW-1:0] beat_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [BEAT_W-1:0] rsp_data_q;

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [BEAT_IW-1:0] word;
  logic               accept, hit, lk_valid, lk_dirty, victim_dirty;
  logic [TAG_W-1:0]   lk_tag;

  ts_cmd_e            ts_cmd;
  logic               ram_we, ram_re;
  logic [RAM_AW-1:0]  ram_addr;
  logic [BEAT_W-1:0]  ram_wdata, ram_rdata;
  logic               fin, fin_err, beat_clr, beat_inc;

  dcm_ea_gen #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_ea (
    .base_sel(req_base_sel), .base_val(req_base), .index_val(req_index), .ea(ea_c)
  );

  assign idx  = ea_q[OFF_W +: IDX_W];
  assign tag  = ea_q[ADDR_W-1 -: TAG_W];
  assign word = ea_q[WLSB +: BEAT_IW];

  dcm_tag_store #(.NLINES(NLINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(idx), .cmd(ts_cmd), .new_tag(tag),
    .valid_o(lk_valid), .dirty_o(lk_dirty), .tag_o(lk_tag)
  );

  dcm_line_ram #(.W(BEAT_W), .DEPTH(NLINES * BEATS)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign hit          = lk_valid && (lk_tag == tag);
  assign victim_dirty = lk_valid && lk_dirty;
  assign req_ready    = (st == S_IDLE) && !rsp_valid_q;
  assign accept       = req_valid && req_ready;

  always_comb begin
    nxt       = st;
    ts_cmd    = TS_NONE;
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = {idx, beat_q};
    ram_wdata = '0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    beat_clr  = 1'b0;
    beat_inc  = 1'b0;
    case (st)
      S_IDLE: if (accept) nxt = S_LOOK;
      S_LOOK: begin
        beat_clr = 1'b1;
        if (fault_q || op_q > 3'd5 || (op_q == OP_DISCARD && !priv_q)) begin
          fin = 1'b1;
          fin_err = 1'b1;
        end else begin
          case (op_q)
            OP_LOAD: begin
              if (hit) begin
                ram_re   = 1'b1;
                ram_addr = {idx, word};
                nxt      = S_RD;
              end else begin
                nxt = victim_dirty ? S_WB_CMD : S_RF_CMD;
              end
            end
            OP_STORE: begin
              if (hit) begin
                ram_we    = 1'b1;
                ram_addr  = {idx, word};
                ram_wdata = wd_q;
                ts_cmd    = TS_MARK_DIRTY;
                fin       = 1'b1;
              end else begin
                nxt = victim_dirty ? S_WB_CMD : S_RF_CMD;
              end
            end
            OP_FLUSH: begin
              if (hit && lk_dirty) nxt = S_WB_CMD;
              else begin
                if (hit) ts_cmd = TS_DROP;
                fin = 1'b1;
              end
            end
            OP_CLEAN: begin
              if (hit && lk_dirty) nxt = S_WB_CMD;
              else fin = 1'b1;
            end
            OP_DISCARD: begin
              if (hit) ts_cmd = TS_DROP;
              fin = 1'b1;
            end
            default: begin
              if (!hit && victim_dirty) nxt = S_WB_CMD;
              else nxt = S_ZFILL;
            end
          endcase
        end
        if (fin) nxt = S_IDLE;
      end
      S_WB_CMD: if (mem_cmd_ready) nxt = S_WB_RD;
      S_WB_RD: begin
        ram_re = 1'b1;
        nxt    = S_WB_BEAT;
      end
      S_WB_BEAT: begin
        if (mem_wready) begin
          if (beat_q == LAST_BEAT) begin
            ts_cmd = TS_MARK_CLEAN;
            nxt    = S_LOOK;
          end else begin
            beat_inc = 1'b1;
            nxt      = S_WB_RD;
          end
        end
      end
      S_RF_CMD: if (mem_cmd_ready) nxt = S_RF_DATA;
      S_RF_DATA: begin
        if (mem_rvalid) begin
          ram_we    = 1'b1;
          ram_wdata = mem_rdata;
          beat_inc  = 1'b1;
          if (beat_q == LAST_BEAT) begin
            ts_cmd = TS_FILL_CLEAN;
            nxt    = S_LOOK;
          end
        end
      end
      S_ZFILL: begin
        ram_we   = 1'b1;
        beat_inc = 1'b1;
        if (beat_q == LAST_BEAT) begin
          ts_cmd = TS_FILL_DIRTY;
          fin    = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_RD: begin
        fin = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ea_q        <= '0;
      op_q        <= '0;
      priv_q      <= 1'b0;
      fault_q     <= 1'b0;
      wd_q        <= '0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      st          <= nxt;
      rsp_valid_q <= fin;
      if (fin) begin
        rsp_err_q  <= fin_err;
        rsp_data_q <= (st == S_RD) ? ram_rdata : '0;
      end
      if (beat_clr)      beat_q <= '0;
      else if (beat_inc) beat_q <= beat_q + 1'b1;
      if (accept) begin
        ea_q    <= ea_c;
        op_q    <= req_op;
        priv_q  <= req_priv;
        fault_q <= req_fault;
        wd_q    <= req_wdata;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_err       = rsp_err_q;
  assign rsp_rdata     = rsp_data_q;
  assign mem_cmd_valid = (st == S_WB_CMD) || (st == S_RF_CMD);
  assign mem_cmd_write = (st == S_WB_CMD);
  assign mem_cmd_addr  = {(st == S_WB_CMD) ? lk_tag : tag, idx, OFF_W'(0)};
  assign mem_wvalid    = (st == S_WB_BEAT);
  assign mem_wdata     = ram_rdata;
endmodule

// File: rtl/dcm_ctrl_chk.sv
module dcm_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 64,
  parameter int LINE_BYTES = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              req_priv,
  input logic              req_fault,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [BEAT_W-1:0] rsp_rdata,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_write,
  input logic [ADDR_W-1:0] mem_cmd_addr,
  input logic              mem_wvalid,
  input logic              mem_wready,
  input logic [BEAT_W-1:0] mem_wdata
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [2:0] c_op;
  logic       c_priv, c_fault, c_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_op <= '0; c_priv <= 1'b0; c_fault <= 1'b0; c_busy <= 1'b0;
    end else if (req_valid && req_ready) begin
      c_op <= req_op; c_priv <= req_priv; c_fault <= req_fault; c_busy <= 1'b1;
    end else if (rsp_valid) begin
      c_busy <= 1'b0;
    end
  end

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));
  a_r10_beat_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_wdata)));
  a_r2_line_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> (mem_cmd_addr[OFF_W-1:0] == '0));
  a_r9_no_result_data: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && c_op != 3'd0) |-> (rsp_rdata == '0));
  a_r5_user_discard_err: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && c_op == 3'd4 && !c_priv) |-> rsp_err);
  a_r7_fault_err: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && c_fault) |-> rsp_err);
  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    (c_busy && c_fault) |-> (!mem_cmd_valid && !mem_wvalid));
  a_r6_zero_no_read: assert property (@(posedge clk) disable iff (rst)
    (c_busy && c_op == 3'd5) |-> !(mem_cmd_valid && !mem_cmd_write));
endmodule

bind dcm_ctrl dcm_ctrl_chk #(
  .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_priv(req_priv), .req_fault(req_fault),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
  .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata)
);

// File: tb/dcm_ctrl_tb_top.sv
`timescale 1ns/1ps
module dcm_ctrl_tb_top;
  import dcm_pkg::*;

  localparam int MEM_WORDS = 2048;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  bsel;
    logic [31:0] base;
    logic [31:0] index;
    logic [63:0] wd;
    logic        priv;
    logic        fault;
    logic        err;
    logic [63:0] rd;
    logic [4:0]  wb;
    logic [1:0]  rc;
    logic [31:0] waddr;
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [63:0] minit(input int w);
    return {32'hC0DE_0000 | 32'(w), 32'(w) ^ 32'h5A5A_5A5A};
  endfunction

  function automatic vec_t mk(input logic [2:0] op, input logic [4:0] bs,
      input logic [31:0] b, input logic [31:0] ix, input logic [63:0] wd,
      input logic pv, input logic ft, input logic er, input logic [63:0] rd,
      input logic [4:0] wb, input logic [1:0] rc, input logic [31:0] wa,
      input logic [3:0] rq);
    vec_t v;
    v.op = op; v.bsel = bs; v.base = b; v.index = ix; v.wd = wd;
    v.priv = pv; v.fault = ft; v.err = er; v.rd = rd; v.wb = wb;
    v.rc = rc; v.waddr = wa; v.rq = rq;
    return v;
  endfunction

  localparam logic [63:0] W1 = 64'h1111_2222_3333_4444;
  localparam logic [63:0] W2 = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam logic [63:0] W3 = 64'hDEAD_BEEF_0000_0001;
  localparam logic [63:0] W4 = 64'h5555_6666_7777_8888;
  localparam logic [63:0] W5 = 64'h7777_0000_0000_7777;
  localparam int NV = 31;

  localparam vec_t VEC [NV] = '{
    mk(OP_LOAD,    3, 32'h100,  32'h8,    0,  0,0, 0, minit(32'h108>>3), 0, 1, 0, 11),      // R11 R1
    mk(OP_LOAD,    0, 32'h9999, 32'h110,  0,  0,0, 0, minit(32'h110>>3), 0, 0, 0, 1),       // R1 zero base
    mk(OP_STORE,   1, 32'h100,  32'h18,   W1, 0,0, 0, 0, 0, 0, 0, 11),                      // R11 store hit
    mk(OP_LOAD,    2, 32'h11F,  32'h0,    0,  0,0, 0, W1, 0, 0, 0, 2),                      // R2 word select
    mk(OP_CLEAN,   2, 32'h100,  32'h7F,   0,  0,0, 0, 0, 16, 0, 32'h100, 4),                // R4 R2
    mk(OP_CLEAN,   2, 32'h100,  32'h7F,   0,  0,0, 0, 0, 0, 0, 0, 4),                       // R4 repeat
    mk(OP_LOAD,    4, 32'h110,  32'h8,    0,  0,0, 0, W1, 0, 0, 0, 4),                      // R4 still valid
    mk(OP_STORE,   0, 32'h0,    32'h120,  W2, 0,0, 0, 0, 0, 0, 0, 11),                     // R11
    mk(OP_FLUSH,   0, 32'h5555, 32'h100,  0,  0,0, 0, 0, 16, 0, 32'h100, 3),                // R3 R1
    mk(OP_LOAD,    0, 32'h0,    32'h120,  0,  0,0, 0, W2, 0, 1, 0, 3),                      // R3 refill
    mk(OP_LOAD,    0, 32'h0,    32'h118,  0,  0,0, 0, W1, 0, 0, 0, 3),                      // R3 order
    mk(OP_STORE,   0, 32'h0,    32'h130,  W3, 0,0, 0, 0, 0, 0, 0, 11),                     // R11
    mk(OP_DISCARD, 0, 32'h0,    32'h100,  0,  0,0, 1, 0, 0, 0, 0, 5),                       // R5 user
    mk(OP_LOAD,    0, 32'h0,    32'h130,  0,  0,0, 0, W3, 0, 0, 0, 5),                      // R5 unchanged
    mk(OP_DISCARD, 0, 32'h0,    32'h17F,  0,  1,0, 0, 0, 0, 0, 0, 5),                       // R5 privileged
    mk(OP_LOAD,    0, 32'h0,    32'h130,  0,  0,0, 0, minit(32'h130>>3), 0, 1, 0, 5),       // R5 data lost
    mk(OP_FLUSH,   0, 32'h0,    32'h4000, 0,  0,0, 0, 0, 0, 0, 0, 8),                       // R8
    mk(OP_CLEAN,   0, 32'h0,    32'h4080, 0,  0,0, 0, 0, 0, 0, 0, 8),                       // R8
    mk(OP_DISCARD, 0, 32'h0,    32'h4100, 0,  1,0, 0, 0, 0, 0, 0, 8),                       // R8
    mk(OP_STORE,   0, 32'h0,    32'h2100, W4, 0,0, 0, 0, 0, 1, 0, 11),                     // R11 clean victim
    mk(OP_ZERO,    0, 32'h0,    32'h108,  0,  0,0, 0, 0, 16, 0, 32'h2100, 6),               // R6 dirty victim
    mk(OP_LOAD,    0, 32'h0,    32'h108,  0,  0,0, 0, 0, 0, 0, 0, 6),                       // R6 zeros
    mk(OP_LOAD,    0, 32'h0,    32'h2100, 0,  0,0, 0, W4, 16, 1, 32'h100, 6),               // R6 R11
    mk(OP_LOAD,    0, 32'h0,    32'h108,  0,  0,0, 0, 0, 0, 1, 0, 6),                       // R6 written back
    mk(OP_STORE,   0, 32'h0,    32'h108,  W5, 0,0, 0, 0, 0, 0, 0, 11),                     // R11
    mk(OP_FLUSH,   0, 32'h0,    32'h108,  0,  0,1, 1, 0, 0, 0, 0, 7),                       // R7 fault
    mk(OP_LOAD,    0, 32'h0,    32'h108,  0,  0,0, 0, W5, 0, 0, 0, 7),                      // R7 untouched
    mk(3'd6,       0, 32'h0,    32'h108,  0,  1,0, 1, 0, 0, 0, 0, 9),                       // R9 bad code
    mk(OP_ZERO,    0, 32'h0,    32'h100,  0,  0,0, 0, 0, 0, 0, 0, 6),                       // R6 hit dirty
    mk(OP_LOAD,    0, 32'h0,    32'h110,  0,  0,0, 0, 0, 0, 0, 0, 6),                       // R6
    mk(OP_LOAD,    0, 32'h0,    32'h108,  0,  0,0, 0, 0, 0, 0, 0, 6)                        // R6
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [4:0] req_base_sel = '0;
  logic [31:0] req_base = '0, req_index = '0;
  logic [63:0] req_wdata = '0;
  logic req_priv = 1'b0, req_fault = 1'b0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [31:0] mem_cmd_addr;
  logic mem_wvalid, mem_wready;
  logic [63:0] mem_wdata;
  logic mem_rvalid;
  logic [63:0] mem_rdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dcm_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base_sel(req_base_sel), .req_base(req_base),
    .req_index(req_index), .req_wdata(req_wdata), .req_priv(req_priv),
    .req_fault(req_fault), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_wvalid(mem_wvalid),
    .mem_wready(mem_wready), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: ready every other cycle, read beats on alternate cycles
  logic [63:0] mem [MEM_WORDS];
  logic        tgl;
  int          wr_base, wr_n, rd_base, rd_n, wbeat_cnt, rdcmd_cnt;
  logic        rd_act;
  logic [31:0] last_waddr;

  assign mem_cmd_ready = tgl;
  assign mem_wready    = tgl;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= minit(i);
      tgl <= 1'b0; rd_act <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      wr_base <= 0; wr_n <= 0; rd_base <= 0; rd_n <= 0;
      wbeat_cnt <= 0; rdcmd_cnt <= 0; last_waddr <= '0;
    end else begin
      tgl <= ~tgl;
      if (mem_cmd_valid && mem_cmd_ready) begin
        if (mem_cmd_write) begin
          wr_base <= int'(mem_cmd_addr[13:3]); wr_n <= 0; last_waddr <= mem_cmd_addr;
        end else begin
          rd_base <= int'(mem_cmd_addr[13:3]); rd_n <= 0; rd_act <= 1'b1;
          rdcmd_cnt <= rdcmd_cnt + 1;
        end
      end
      if (mem_wvalid && mem_wready) begin
        mem[(wr_base + wr_n) % MEM_WORDS] <= mem_wdata;
        wr_n <= wr_n + 1;
        wbeat_cnt <= wbeat_cnt + 1;
      end
      mem_rvalid <= 1'b0;
      if (rd_act && tgl) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[(rd_base + rd_n) % MEM_WORDS];
        rd_n <= rd_n + 1;
        if (rd_n == 15) rd_act <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int wb0, rc0;
    while (!req_ready) @(negedge clk);
    wb0 = wbeat_cnt; rc0 = rdcmd_cnt;
    req_op = v.op; req_base_sel = v.bsel; req_base = v.base; req_index = v.index;
    req_wdata = v.wd; req_priv = v.priv; req_fault = v.fault; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, 10, "ready low while busy", 64'(req_ready), 0);  // R10
    while (!rsp_valid) @(negedge clk);
    chk(rsp_err == v.err, v.rq, "error flag", 64'(rsp_err), 64'(v.err));
    chk(rsp_rdata == v.rd, v.rq, "response data", rsp_rdata, v.rd);
    chk(wbeat_cnt - wb0 == int'(v.wb), v.rq, "write beats", 64'(wbeat_cnt - wb0), 64'(v.wb));
    chk(rdcmd_cnt - rc0 == int'(v.rc), v.rq, "read commands", 64'(rdcmd_cnt - rc0), 64'(v.rc));
    if (v.wb != 0)
      chk(last_waddr == v.waddr, v.rq, "write-back address", 64'(last_waddr), 64'(v.waddr));
    @(negedge clk);
    chk(rsp_valid == 1'b0, 10, "response one cycle", 64'(rsp_valid), 0);  // R10
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, 12, "ready after reset", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, 12, "no response after reset", 64'(rsp_valid), 0);
    chk(mem_cmd_valid == 1'b0, 12, "no command after reset", 64'(mem_cmd_valid), 0);
    chk(mem_wvalid == 1'b0, 12, "no beat after reset", 64'(mem_wvalid), 0);

    for (int i = 0; i < NV; i++) run(VEC[i]);

    // R12: reset mid-run drops every line; first access misses again
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    run(mk(OP_LOAD, 0, 32'h0, 32'h108, 0, 0, 0, 0, minit(32'h108>>3), 0, 1, 0, 12));
    // R1: base register index 0 with a large base value still addresses from zero
    run(mk(OP_LOAD, 0, 32'hFFFF_0000, 32'h110, 0, 0, 0, 0, minit(32'h110>>3), 0, 0, 0, 1));
    // R9: code 7 rejected
    run(mk(3'd7, 0, 32'h0, 32'h108, 0, 1, 0, 1, 0, 0, 0, 0, 9));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule